// File: doc/BRIEF.md
# Indirect Register Port for a Serial Channel

This block is the host side of a serial channel's register file. A host reaches it over a small bus with two addresses. Address 0 is the control port and address 1 is the data port. The channel has sixteen 8-bit write registers and a set of read registers. None of them has its own bus address. The host reaches them through a 4-bit register pointer.

On the control port, the first write goes to register 0. Its low nibble loads the pointer, and its command field can issue a one-shot command to the channel. If that loaded pointer is nonzero, the next control-port access writes or reads the selected register, and the pointer then returns to zero. A control-port read with the pointer at zero returns the live channel status.

The data port bypasses the pointer. A write loads the transmit holding register, and a read pops the receive buffer. The serial shifters sit outside this block. They see the write bank as a flat vector, together with the transmit-load, receive-pop and command strobes.

Top module: `sio_regport`

## Requirements
- R1: After reset the pointer is zero, all sixteen write registers read as zero on `wreg_flat`, and `tx_load`, `rx_pop` and the four command strobes are low.
- R2: A control-port write while the pointer is zero stores the whole byte in write register 0 and loads the pointer from bits [3:0] of the byte. A pointer field of 0 leaves the next control access aimed at register 0 again.
- R3: A control-port write while the pointer is nonzero stores the byte in the write register the pointer selects, issues no command, and returns the pointer to zero. The new contents appear on `wreg_flat` (register k at bits [8k+7:8k]) in the cycle after the write.
- R4: A control-port read while the pointer is nonzero returns the selected read register on `bus_rdata` in the same cycle, and the pointer returns to zero. Index 1 returns {5'b0, rx_err}, index 3 returns `int_pend`, and every other nonzero index returns the write register with the same index.
- R5: A control-port read while the pointer is zero returns the status byte. Bit 0 is rx_avail, bit 1 tx_empty, bit 2 line_cts, bit 3 line_dcd, bit 4 line_sync, bit 5 line_brk, and bits 7:6 are zero. The pointer stays zero.
- R6: A data-port write raises `tx_load` for exactly one cycle, in the cycle after the write, with `tx_data` equal to the written byte. The pointer is unchanged.
- R7: A data-port read drives `bus_rdata` with `rx_data` and raises `rx_pop` in the same cycle. The pointer is unchanged.
- R8: Bits [6:4] of a register-0 write are a command code. Code 1 pulses `cmd_rst_ext`, 2 pulses `cmd_rst_err`, 3 pulses `cmd_rst_txip` and 4 pulses `cmd_rst_ius`, each for exactly one cycle in the cycle after the write. Codes 0, 5, 6 and 7 pulse nothing. At most one command strobe is high at a time.
- R9: A cycle with both `bus_wr` and `bus_rd` high is treated as a write only. The read does not clear the pointer and raises no `rx_pop`.
- R10: With no bus access the pointer holds, and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = control port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| rx_data | input | 8 | Head of the receive buffer |
| rx_avail | input | 1 | Receive character available |
| tx_empty | input | 1 | Transmit buffer empty |
| line_cts | input | 1 | Clear-to-send level |
| line_dcd | input | 1 | Carrier-detect level |
| line_sync | input | 1 | Sync/hunt level |
| line_brk | input | 1 | Break detected |
| rx_err | input | 3 | Receive error flags (parity, overrun, framing) |
| int_pend | input | 8 | Interrupt pending flags |
| rx_pop | output | 1 | Receive buffer pop |
| tx_load | output | 1 | Transmit holding register load |
| tx_data | output | 8 | Byte for the transmit holding register |
| cmd_rst_ext | output | 1 | Reset external/status interrupt |
| cmd_rst_err | output | 1 | Reset receive error |
| cmd_rst_txip | output | 1 | Reset transmit interrupt pending |
| cmd_rst_ius | output | 1 | Reset highest interrupt under service |
| wreg_flat | output | 128 | All sixteen write registers, register k at [8k+7:8k] |

## Verification
Read results, from both the status byte and the indexed read registers, are combinational. The bench samples them partway through the read cycle, before the closing edge. Write-register contents, `tx_load` and the command strobes are registered. The bench drives each access on a falling edge and checks these results on the falling edge after the capturing rising edge. It then checks them once more a cycle later to confirm that each strobe has fallen. To observe the pointer, which has no port of its own, the bench follows each access with a control read. That read must return either the status byte or the register it expects.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;

  // command codes carried in bits [6:4] of register 0
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_RST_EXT  = 3'd1,
    CMD_RST_ERR  = 3'd2,
    CMD_RST_TXIP = 3'd3,
    CMD_RST_IUS  = 3'd4
  } cmd_e;

  // one-hot strobe vector, bit order {ius, txip, err, ext}
  function automatic logic [3:0] cmd_strobes(input logic [2:0] code);
    logic [3:0] s;
    s = 4'b0000;
    case (cmd_e'(code))
      CMD_RST_EXT:  s = 4'b0001;
      CMD_RST_ERR:  s = 4'b0010;
      CMD_RST_TXIP: s = 4'b0100;
      CMD_RST_IUS:  s = 4'b1000;
      default:      s = 4'b0000;
    endcase
    return s;
  endfunction

  function automatic logic [7:0] pack_status(
    input logic rx_avail, input logic tx_empty, input logic cts,
    input logic dcd, input logic sync, input logic brk);
    return {2'b00, brk, sync, dcd, cts, tx_empty, rx_avail};
  endfunction

endpackage

// File: rtl/srp_ptr_fsm.sv
module srp_ptr_fsm #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic [PTR_W-1:0] wdata_ptr,
  output logic [PTR_W-1:0] ptr,
  output logic             wr0_hit,
  output logic             wrx_hit
);
  logic [PTR_W-1:0] ptr_q;
  logic             ptr_zero;

  assign ptr_zero = (ptr_q == '0);
  assign wr0_hit  = ctl_wr & ptr_zero;
  assign wrx_hit  = ctl_wr & ~ptr_zero;
  assign ptr      = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr0_hit) begin
      ptr_q <= wdata_ptr;
    end else if (wrx_hit || ctl_rd) begin
      ptr_q <= '0;
    end
  end
endmodule

// File: rtl/srp_wreg_bank.sv
module srp_wreg_bank #(
  parameter int DW    = 8,
  parameter int NREG  = 16,
  parameter int PTR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [PTR_W-1:0]          idx,
  input  logic [DW-1:0]             din,
  output logic [NREG-1:0][DW-1:0]   regs
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic hit;
    assign hit = we && (idx == PTR_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[k] <= '0;
      end else if (hit) begin
        regs[k] <= din;
      end
    end
  end
endmodule

// File: rtl/srp_cmd_dec.sv
module srp_cmd_dec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr0_hit,
  input  logic [2:0] code,
  output logic [3:0] strobes
);
  import sio_regport_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobes <= 4'b0000;
    end else if (wr0_hit) begin
      strobes <= cmd_strobes(code);
    end else begin
      strobes <= 4'b0000;
    end
  end
endmodule

// File: rtl/srp_read_mux.sv
module srp_read_mux #(
  parameter int DW      = 8,
  parameter int NREG    = 16,
  parameter int PTR_W   = 4,
  parameter int ERR_IDX = 1,
  parameter int IP_IDX  = 3
) (
  input  logic                    ctl_rd,
  input  logic                    dat_rd,
  input  logic [PTR_W-1:0]        ptr,
  input  logic [DW-1:0]           status,
  input  logic [DW-1:0]           err_reg,
  input  logic [DW-1:0]           ip_reg,
  input  logic [DW-1:0]           rx_data,
  input  logic [NREG-1:0][DW-1:0] regs,
  output logic [DW-1:0]           rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    if (ptr == '0)                        sel = status;
    else if (ptr == PTR_W'(ERR_IDX))      sel = err_reg;
    else if (ptr == PTR_W'(IP_IDX))       sel = ip_reg;
    else                                  sel = regs[ptr];
  end

  always_comb begin
    if (dat_rd)      rdata = rx_data;
    else if (ctl_rd) rdata = sel;
    else             rdata = '0;
  end
endmodule

// File: rtl/sio_regport.sv
module sio_regport #(
  parameter int DW      = 8,
  parameter int NREG    = 16,
  parameter int ERR_W   = 3,
  parameter int ERR_IDX = 1,
  parameter int IP_IDX  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [DW-1:0]      rx_data,
  input  logic               rx_avail,
  input  logic               tx_empty,
  input  logic               line_cts,
  input  logic               line_dcd,
  input  logic               line_sync,
  input  logic               line_brk,
  input  logic [ERR_W-1:0]   rx_err,
  input  logic [DW-1:0]      int_pend,
  output logic               rx_pop,
  output logic               tx_load,
  output logic [DW-1:0]      tx_data,
  output logic               cmd_rst_ext,
  output logic               cmd_rst_err,
  output logic               cmd_rst_txip,
  output logic               cmd_rst_ius,
  output logic [NREG*DW-1:0] wreg_flat
);
  import sio_regport_pkg::*;

  localparam int PTR_W = $clog2(NREG);

  // named access events
  logic ctl_wr, ctl_rd, dat_wr, dat_rd;
  assign ctl_wr = bus_wr & ~bus_addr;
  assign dat_wr = bus_wr &  bus_addr;
  assign ctl_rd = bus_rd & ~bus_wr & ~bus_addr;
  assign dat_rd = bus_rd & ~bus_wr &  bus_addr;

  logic [PTR_W-1:0] ptr_q;
  logic             wr0_hit, wrx_hit;

  srp_ptr_fsm #(.PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_rd    (ctl_rd),
    .wdata_ptr (bus_wdata[PTR_W-1:0]),
    .ptr       (ptr_q),
    .wr0_hit   (wr0_hit),
    .wrx_hit   (wrx_hit)
  );

  logic [NREG-1:0][DW-1:0] regs;

  srp_wreg_bank #(.DW(DW), .NREG(NREG), .PTR_W(PTR_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_wr),
    .idx   (ptr_q),
    .din   (bus_wdata),
    .regs  (regs)
  );
  assign wreg_flat = regs;

  logic [3:0] cmd_vec;

  srp_cmd_dec u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr0_hit (wr0_hit),
    .code    (bus_wdata[6:4]),
    .strobes (cmd_vec)
  );
  assign cmd_rst_ext  = cmd_vec[0];
  assign cmd_rst_err  = cmd_vec[1];
  assign cmd_rst_txip = cmd_vec[2];
  assign cmd_rst_ius  = cmd_vec[3];

  logic [DW-1:0] status_b, err_b;
  assign status_b = DW'(pack_status(rx_avail, tx_empty, line_cts,
                                    line_dcd, line_sync, line_brk));
  assign err_b    = DW'(rx_err);

  srp_read_mux #(.DW(DW), .NREG(NREG), .PTR_W(PTR_W),
                 .ERR_IDX(ERR_IDX), .IP_IDX(IP_IDX)) u_rmux (
    .ctl_rd  (ctl_rd),
    .dat_rd  (dat_rd),
    .ptr     (ptr_q),
    .status  (status_b),
    .err_reg (err_b),
    .ip_reg  (int_pend),
    .rx_data (rx_data),
    .regs    (regs),
    .rdata   (bus_rdata)
  );

  assign rx_pop = dat_rd;

  // transmit holding load, one cycle after the data-port write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_load <= 1'b0;
      tx_data <= '0;
    end else begin
      tx_load <= dat_wr;
      if (dat_wr) tx_data <= bus_wdata;
    end
  end
endmodule

// File: rtl/sio_regport_chk.sv
module sio_regport_chk #(
  parameter int DW    = 8,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [PTR_W-1:0] ptr,
  input logic             tx_load,
  input logic [DW-1:0]    tx_data,
  input logic             rx_pop,
  input logic [3:0]       cmd_vec
);
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && ptr == '0) |=> ptr == $past(bus_wdata[PTR_W-1:0])); // R2

  AST_PTR_CLR_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && ptr != '0) |=> ptr == '0); // R3

  AST_PTR_CLR_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_addr) |=> ptr == '0); // R4

  AST_PTR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr || (!bus_wr && !bus_rd)) |=> $stable(ptr)); // R10

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> ($past(bus_wr && bus_addr) && tx_data == $past(bus_wdata))); // R6

  AST_RX_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_rd && !bus_wr && bus_addr)); // R7

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_vec)); // R8

  AST_CMD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vec != 4'b0) |-> $past(bus_wr && !bus_addr && ptr == '0)); // R8

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_wr) |-> bus_rdata == '0); // R10
endmodule

bind sio_regport sio_regport_chk #(.DW(DW), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ptr       (ptr_q),
  .tx_load   (tx_load),
  .tx_data   (tx_data),
  .rx_pop    (rx_pop),
  .cmd_vec   (cmd_vec)
);

// File: tb/sio_regport_tb.sv
module sio_regport_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_wdata = 8'h00;
  logic [7:0]   bus_rdata;
  logic [7:0]   rx_data = 8'h00;
  logic         rx_avail = 1'b0, tx_empty = 1'b0, line_cts = 1'b0;
  logic         line_dcd = 1'b0, line_sync = 1'b0, line_brk = 1'b0;
  logic [2:0]   rx_err = 3'b000;
  logic [7:0]   int_pend = 8'h00;
  logic         rx_pop, tx_load;
  logic [7:0]   tx_data;
  logic         cmd_rst_ext, cmd_rst_err, cmd_rst_txip, cmd_rst_ius;
  logic [127:0] wreg_flat;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [7:0] shadow [16];

  sio_regport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .rx_avail(rx_avail), .tx_empty(tx_empty),
    .line_cts(line_cts), .line_dcd(line_dcd), .line_sync(line_sync),
    .line_brk(line_brk), .rx_err(rx_err), .int_pend(int_pend),
    .rx_pop(rx_pop), .tx_load(tx_load), .tx_data(tx_data),
    .cmd_rst_ext(cmd_rst_ext), .cmd_rst_err(cmd_rst_err),
    .cmd_rst_txip(cmd_rst_txip), .cmd_rst_ius(cmd_rst_ius),
    .wreg_flat(wreg_flat)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {2'b00, line_brk, line_sync, line_dcd, line_cts, tx_empty, rx_avail};
  endfunction

  function automatic logic [3:0] exp_cmd(input logic [2:0] c);
    if (c >= 3'd1 && c <= 3'd4) return 4'b0001 << (c - 3'd1);
    return 4'b0000;
  endfunction

  function automatic logic [3:0] cmd_now();
    return {cmd_rst_ius, cmd_rst_txip, cmd_rst_err, cmd_rst_ext};
  endfunction

  // each task starts and ends on a falling edge
  task automatic access(input logic a, input logic w, input logic r, input logic [7:0] d);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00; bus_addr = 1'b0;
  endtask

  task automatic ctl_rd(output logic [7:0] v, output logic pop);
    bus_addr = 1'b0; bus_rd = 1'b1;
    #3;
    v = bus_rdata; pop = rx_pop;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    logic       pop;
    for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 wregs", wreg_flat, 128'h0);
    check("R1 strobes", {tx_load, rx_pop, cmd_now()}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle rdata", bus_rdata, 8'h00);

    // R5: status sweep with pointer at zero
    for (int s = 0; s < 64; s++) begin
      {line_brk, line_sync, line_dcd, line_cts, tx_empty, rx_avail} = 6'(s);
      ctl_rd(v, pop);
      check("R5 status", v, exp_status());
      check("R7 no pop on ctl read", pop, 1'b0);
    end

    rx_err = 3'b101;
    int_pend = 8'hC6;
    // R3/R4: indirect write and read of every nonzero index
    for (int i = 1; i < 16; i++) begin
      logic [7:0] val;
      val = 8'((i * 37 + 27) & 8'hFF);
      access(1'b0, 1'b1, 1'b0, 8'(i));
      access(1'b0, 1'b1, 1'b0, val);
      check("R3 no cmd on indirect", cmd_now(), 4'b0000);
      shadow[0] = 8'(i);
      shadow[i] = val;
      check("R3 wreg slot", wreg_flat[i*8 +: 8], val);
      check("R2 wreg0 holds index", wreg_flat[7:0], 8'(i));
      access(1'b0, 1'b1, 1'b0, 8'(i));
      ctl_rd(v, pop);
      if (i == 1)      check("R4 err index", v, {5'b0, rx_err});
      else if (i == 3) check("R4 ip index", v, int_pend);
      else             check("R4 readback", v, val);
      ctl_rd(v, pop);
      check("R4 pointer cleared", v, exp_status());
    end
    check("R3 full bank", wreg_flat,
          {shadow[15], shadow[14], shadow[13], shadow[12], shadow[11], shadow[10],
           shadow[9], shadow[8], shadow[7], shadow[6], shadow[5], shadow[4],
           shadow[3], shadow[2], shadow[1], shadow[0]});

    // R8: every command code, pointer field zero
    for (int c = 0; c < 8; c++) begin
      access(1'b0, 1'b1, 1'b0, {1'b1, 3'(c), 4'h0});
      check("R8 cmd strobe", cmd_now(), exp_cmd(3'(c)));
      check("R2 wreg0 byte", wreg_flat[7:0], {1'b1, 3'(c), 4'h0});
      @(negedge clk);
      check("R8 strobe one cycle", cmd_now(), 4'b0000);
      ctl_rd(v, pop);
      check("R2 zero pointer stays at reg0", v, exp_status());
    end

    // R8/R2: command and pointer in the same write; indirect write carries no command
    access(1'b0, 1'b1, 1'b0, 8'h25);
    check("R8 cmd with pointer", cmd_now(), 4'b0010);
    access(1'b0, 1'b1, 1'b0, 8'h40);
    check("R3 cmd bits ignored indirect", cmd_now(), 4'b0000);
    check("R3 reg5", wreg_flat[47:40], 8'h40);

    // R6/R7: data port leaves the pointer alone
    access(1'b0, 1'b1, 1'b0, 8'h07);
    access(1'b1, 1'b1, 1'b0, 8'h3C);
    check("R6 tx_load", tx_load, 1'b1);
    check("R6 tx_data", tx_data, 8'h3C);
    @(negedge clk);
    check("R6 tx_load one cycle", tx_load, 1'b0);
    rx_data = 8'h9E;
    bus_addr = 1'b1; bus_rd = 1'b1;
    #3;
    check("R7 rx data", bus_rdata, 8'h9E);
    check("R7 rx_pop", rx_pop, 1'b1);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; bus_addr = 1'b0;
    ctl_rd(v, pop);
    check("R7 pointer kept", v, shadow[7]);

    // R9: simultaneous write and read
    access(1'b0, 1'b1, 1'b0, 8'h09);
    access(1'b1, 1'b1, 1'b1, 8'h5A);
    check("R9 data write wins", tx_load, 1'b1);
    access(1'b0, 1'b1, 1'b1, 8'h77);
    check("R9 ctl write wins", wreg_flat[79:72], 8'h77);
    ctl_rd(v, pop);
    check("R9 pointer cleared by write", v, exp_status());
    access(1'b0, 1'b1, 1'b0, 8'h0B);
    bus_addr = 1'b1; bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 8'h11;
    #3;
    check("R9 no rx_pop", rx_pop, 1'b0);
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 1'b0;
    repeat (3) @(negedge clk);
    ctl_rd(v, pop);
    check("R10 pointer held over idle", v, shadow[11]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule